// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits beside a synchronous DRAM command bus and only listens. On every clock it turns the chip-select, row-strobe, column-strobe and write-enable pins into a command code. It checks that command against the state of each bank the command reaches. A bank moves through idle, row active, write recovery (plain or with auto-precharge), precharging, refresh and mode-register access. Timed states end after a parameterised number of clocks, each counted by that bank's own down-counter.

A command that a targeted bank may not accept in its current state raises a sticky error flag. On the first offence the flag captures the command, the bank and that bank's state. The capture holds until a synchronous clear. An illegal command does not change the state of the bank that refused it. Checking is suspended on any cycle where the clock-enable pin was not high on both that cycle and the one before.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` high, `cmd_code` is 0 (deselect) whatever the strobes are. With `cs_n` low, `{ras_n,cas_n,we_n}` gives `cmd_code` = 8 minus that 3-bit value: 1 no-op, 2 burst stop, 3 read, 4 write, 5 activate, 6 precharge, 7 refresh, 8 mode set.
- R2: `a10` high on a precharge reaches every bank, and `a10` low reaches only bank `ba`. A write with `a10` high enters write recovery with auto-precharge.
- R3: In write recovery (state 2), deselect, no-op, burst stop, read and write are accepted. A read returns the bank to row active at once, and a new write restarts the recovery. With no such command, the bank reads row active T_DPL clocks after the write.
- R4: In write recovery, activate and precharge to that bank are flagged, and so are refresh and mode set.
- R5: In write recovery with auto-precharge (state 3), only deselect and no-op are accepted. The bank becomes precharging (state 4) T_DPL clocks after the write, and idle T_RP clocks later. Commands to the other bank are judged by that bank's own state.
- R6: Refresh sends both banks to state 5. Only deselect, no-op and burst stop are accepted there, and both banks are idle T_RC clocks after the refresh.
- R7: Mode set sends both banks to state 6. Only deselect and no-op are accepted there. A command two clocks after the mode set is judged against idle.
- R8: A command is neither checked nor acted on unless `cke` is high in that cycle and was high in the previous one. During reset the previous-cycle value follows `cke`.
- R9: An illegal command sets `err_flag`. If the flag was clear it records `err_cmd`, `err_bank` and `err_state`, and later offences keep that record. For commands that reach all banks, the lowest offending bank is recorded. `err_clr` clears the flag, but an offence in the same cycle sets it again with a new record. A refused command leaves that bank's state unchanged.
- R10: Reset sets every bank to idle (state 0) and clears the flag. State codes are: 0 idle, 1 row active, 2 write recovery, 3 write recovery with auto-precharge, 4 precharging, 5 refresh, 6 mode access. Bank b is at `bank_state[3b+2:3b]`.
- R11: In idle, read and write are flagged. In row active, activate, refresh and mode set are flagged. In precharging, only deselect, no-op and burst stop are accepted. Activate takes an idle bank to row active. A precharge takes a row active bank to precharging for T_RP clocks. A read with `a10` high does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| err_clr | input | 1 | Synchronous clear of the error capture |
| cmd_code | output | 4 | Decoded command of this cycle |
| bank_state | output | 3*2^BA_W | Registered state per bank |
| err_flag | output | 1 | Sticky illegal-command flag |
| err_cmd | output | 4 | Recorded command code |
| err_bank | output | BA_W | Recorded bank |
| err_state | output | 3 | Recorded bank state |

## Verification
The assertions assume reset is held low for at least two clocks. They also assume the bus pins are known, never X, once reset is released. Timer-exit properties assume that no accepted command arrives on the expiry cycle. The bench keeps to these assumptions: every pin is set on the falling edge from a defined table. Each scenario starts from a fresh two-cycle reset, and the timeout sequences fill every cycle with no-ops.

// File: rtl/sdram_mon_pkg.sv
// Shared command and bank-state encodings for the SDRAM command monitor.
// Assumes: codes are visible on the ports, so their values are fixed.
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESL  = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_BST   = 4'd2,
        CMD_READ  = 4'd3,
        CMD_WRITE = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_MRS   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_ACTIVE  = 3'd1,
        BK_WREC    = 3'd2,
        BK_WREC_AP = 3'd3,
        BK_PRECHG  = 3'd4,
        BK_REFRESH = 3'd5,
        BK_MODE    = 3'd6
    } bank_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: maps the active-low strobes to a command code.
// Assumes: purely combinational; chip select high means deselect.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    // Decode strobe pattern into a command.
    always_comb begin
        if (cs_n_i) begin
            cmd_o = CMD_DESL;
        end else begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b111:  cmd_o = CMD_NOP;
                3'b110:  cmd_o = CMD_BST;
                3'b101:  cmd_o = CMD_READ;
                3'b100:  cmd_o = CMD_WRITE;
                3'b011:  cmd_o = CMD_ACT;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                default: cmd_o = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Per-bank state tracker: judges each command that reaches this bank,
// applies accepted ones, and times the recovery, refresh and mode windows.
// Assumes: every timing parameter is at least 1 clock; a window of N
// clocks means a command N clocks after its start is judged in the next state.
module sdram_bank_track
    import sdram_mon_pkg::*;
#(
    parameter int T_DPL = 2,
    parameter int T_RC  = 6,
    parameter int T_RP  = 3,
    parameter int CNT_W = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  chk_en_i,
    input  logic  hit_i,
    input  cmd_e  cmd_i,
    input  logic  a10_i,
    output bank_e state_o,
    output bank_e eff_o,
    output logic  illegal_o
);

    localparam int MODE_CYC = 2;

    bank_e            state_q, state_d, eff;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             timed, expire, ok, act;

    // Which commands a bank in a given state accepts.
    function automatic logic allowed(bank_e s, cmd_e c);
        case (s)
            BK_IDLE:    return !(c inside {CMD_READ, CMD_WRITE});
            BK_ACTIVE:  return !(c inside {CMD_ACT, CMD_REF, CMD_MRS});
            BK_WREC:    return !(c inside {CMD_ACT, CMD_PRE, CMD_REF, CMD_MRS});
            BK_WREC_AP,
            BK_MODE:    return c inside {CMD_DESL, CMD_NOP};
            default:    return c inside {CMD_DESL, CMD_NOP, CMD_BST};
        endcase
    endfunction

    // Effective state: a window on its last count is already over.
    always_comb begin
        timed  = state_q inside {BK_WREC, BK_WREC_AP, BK_PRECHG, BK_REFRESH, BK_MODE};
        expire = timed && (cnt_q == CNT_W'(1));
        eff    = state_q;
        if (expire) begin
            case (state_q)
                BK_WREC:    eff = BK_ACTIVE;
                BK_WREC_AP: eff = BK_PRECHG;
                default:    eff = BK_IDLE;
            endcase
        end
    end

    assign ok        = allowed(eff, cmd_i);
    assign illegal_o = chk_en_i && hit_i && !ok;
    assign act       = chk_en_i && hit_i && ok;

    // Next state and counter from the effective state and accepted command.
    always_comb begin
        state_d = eff;
        if (expire && state_q == BK_WREC_AP) begin
            cnt_d = CNT_W'(T_RP);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = '0;
        end
        if (act) begin
            case (cmd_i)
                CMD_ACT: begin
                    state_d = BK_ACTIVE;
                    cnt_d   = '0;
                end
                CMD_READ: begin
                    state_d = a10_i ? BK_PRECHG : BK_ACTIVE;
                    cnt_d   = a10_i ? CNT_W'(T_RP) : '0;
                end
                CMD_WRITE: begin
                    state_d = a10_i ? BK_WREC_AP : BK_WREC;
                    cnt_d   = CNT_W'(T_DPL);
                end
                CMD_PRE: begin
                    if (eff == BK_ACTIVE) begin
                        state_d = BK_PRECHG;
                        cnt_d   = CNT_W'(T_RP);
                    end
                end
                CMD_REF: begin
                    state_d = BK_REFRESH;
                    cnt_d   = CNT_W'(T_RC);
                end
                CMD_MRS: begin
                    state_d = BK_MODE;
                    cnt_d   = CNT_W'(MODE_CYC);
                end
                default: ;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
    assign eff_o   = eff;

    AST_WREC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_WREC && cnt_q == CNT_W'(1) && !act) |=> (state_q == BK_ACTIVE)); // R3
    AST_WREC_AP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_WREC_AP && cnt_q == CNT_W'(1)) |=> (state_q == BK_PRECHG)); // R5
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_MODE && cnt_q == CNT_W'(1) && !act) |=> (state_q == BK_IDLE)); // R7
    AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !expire) |=> (state_q == $past(state_q))); // R9

endmodule

// File: rtl/sdram_err_capture.sv
// Sticky error capture: records the first illegal command until cleared.
// Assumes: an offence in the clear cycle wins and is recorded afresh.
module sdram_err_capture
    import sdram_mon_pkg::*;
#(
    parameter int BA_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            hit_i,
    input  cmd_e            cmd_i,
    input  logic [BA_W-1:0] bank_i,
    input  bank_e           state_i,
    output logic            flag_o,
    output cmd_e            cmd_o,
    output logic [BA_W-1:0] bank_o,
    output bank_e           state_o
);

    logic flag_q;

    // Set, hold and clear the flag together with its record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            cmd_o   <= CMD_DESL;
            bank_o  <= '0;
            state_o <= BK_IDLE;
        end else if (hit_i) begin
            flag_q <= 1'b1;
            if (!flag_q || clr_i) begin
                cmd_o   <= cmd_i;
                bank_o  <= bank_i;
                state_o <= state_i;
            end
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> !flag_q); // R9
    AST_RECORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> $stable(cmd_o)); // R9

endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM bank command legality monitor (top). Decodes the bus, routes each
// command to the banks it reaches, and captures the first illegal one.
// Assumes: passive observer; power-down and data checks are elsewhere.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BA_W  = 1,
    parameter int T_DPL = 2,
    parameter int T_RC  = 6,
    parameter int T_RP  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    input  logic                       err_clr,
    output logic [3:0]                 cmd_code,
    output logic [3*(2**BA_W)-1:0]     bank_state,
    output logic                       err_flag,
    output logic [3:0]                 err_cmd,
    output logic [BA_W-1:0]            err_bank,
    output logic [2:0]                 err_state
);

    localparam int NUM_BANKS = 2 ** BA_W;
    localparam int MAX_T     = (T_DPL > T_RC) ? ((T_DPL > T_RP) ? T_DPL : T_RP)
                                              : ((T_RC > T_RP) ? T_RC : T_RP);
    localparam int CNT_W     = $clog2(((MAX_T > 2) ? MAX_T : 2) + 1);

    cmd_e                 cmd;
    logic                 cke_q, chk_en;
    logic [NUM_BANKS-1:0] hit, ill;
    bank_e                st_w  [NUM_BANKS];
    bank_e                eff_w [NUM_BANKS];
    logic [BA_W-1:0]      off_idx;
    bank_e                off_st;
    cmd_e                 rec_cmd;
    bank_e                rec_st;

    sdram_cmd_decode u_dec (
        .cs_n_i  (cs_n),
        .ras_n_i (ras_n),
        .cas_n_i (cas_n),
        .we_n_i  (we_n),
        .cmd_o   (cmd)
    );

    // Previous-cycle clock enable; follows the pin during reset.
    always_ff @(posedge clk) begin
        cke_q <= cke;
    end

    assign chk_en = cke && cke_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Does this cycle's command reach bank b.
        always_comb begin
            case (cmd)
                CMD_READ, CMD_WRITE, CMD_ACT: hit[b] = (ba == BA_W'(b));
                CMD_PRE:                      hit[b] = a10 || (ba == BA_W'(b));
                CMD_BST, CMD_REF, CMD_MRS:    hit[b] = 1'b1;
                default:                      hit[b] = 1'b0;
            endcase
        end

        sdram_bank_track #(
            .T_DPL (T_DPL),
            .T_RC  (T_RC),
            .T_RP  (T_RP),
            .CNT_W (CNT_W)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .chk_en_i  (chk_en),
            .hit_i     (hit[b]),
            .cmd_i     (cmd),
            .a10_i     (a10),
            .state_o   (st_w[b]),
            .eff_o     (eff_w[b]),
            .illegal_o (ill[b])
        );

        assign bank_state[3*b +: 3] = st_w[b];
    end

    // Pick the lowest offending bank for the record.
    always_comb begin
        off_idx = '0;
        off_st  = BK_IDLE;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (ill[i]) begin
                off_idx = BA_W'(i);
                off_st  = eff_w[i];
            end
        end
    end

    sdram_err_capture #(.BA_W(BA_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (err_clr),
        .hit_i   (|ill),
        .cmd_i   (cmd),
        .bank_i  (off_idx),
        .state_i (off_st),
        .flag_o  (err_flag),
        .cmd_o   (rec_cmd),
        .bank_o  (err_bank),
        .state_o (rec_st)
    );

    assign cmd_code  = cmd;
    assign err_cmd   = rec_cmd;
    assign err_state = rec_st;

    AST_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_en && !err_flag) |=> !err_flag); // R8
    AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w[0] == BK_REFRESH) |-> (st_w[NUM_BANKS-1] == BK_REFRESH)); // R6
    AST_MODE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w[0] == BK_MODE) |-> (st_w[NUM_BANKS-1] == BK_MODE)); // R7

endmodule

// File: tb/sdram_cmd_monitor_test.sv
// Self-checking bench: sweeps every bank state against every command,
// then walks the timed windows, CKE gating and the error capture.
module sdram_cmd_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int T_DPL = 2;
    localparam int T_RC  = 6;
    localparam int T_RP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0] ba = '0;
    logic       a10 = 1'b0;
    logic       err_clr = 1'b0;
    logic [3:0] cmd_code;
    logic [5:0] bank_state;
    logic       err_flag;
    logic [3:0] err_cmd;
    logic [0:0] err_bank;
    logic [2:0] err_state;

    int checks = 0;
    int errors = 0;

    sdram_cmd_monitor #(.BA_W(1), .T_DPL(T_DPL), .T_RC(T_RC), .T_RP(T_RP)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .err_clr(err_clr),
        .cmd_code(cmd_code), .bank_state(bank_state), .err_flag(err_flag),
        .err_cmd(err_cmd), .err_bank(err_bank), .err_state(err_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pins for a command code (R1 table: strobes = 8 - code).
    task automatic drive(int c, int b, int a);
        cs_n = (c == 0);
        {ras_n, cas_n, we_n} = (c == 0) ? 3'b111 : 3'(8 - c);
        ba  = 1'(b);
        a10 = 1'(a);
    endtask

    task automatic step(int c, int b, int a);
        @(negedge clk);
        drive(c, b, a);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; err_clr = 1'b0;
        drive(1, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int bs(int b);
        return int'(bank_state[3*b +: 3]);
    endfunction

    // Acceptance per state, written from R3..R7 and R11.
    function automatic bit legal_exp(int s, int c);
        case (s)
            0: return !(c == 3 || c == 4);
            1: return !(c == 5 || c == 7 || c == 8);
            2: return !(c == 5 || c == 6 || c == 7 || c == 8);
            3, 6: return (c == 0 || c == 1);
            default: return (c <= 2);
        endcase
    endfunction

    function automatic string tag(int s);
        case (s)
            2: return "R4";
            3: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic setup(int s);
        case (s)
            1: step(5, 0, 0);
            2: begin step(5, 0, 0); step(4, 0, 0); end
            3: begin step(5, 0, 0); step(4, 0, 1); end
            4: begin step(5, 0, 0); step(6, 0, 0); end
            5: step(7, 0, 0);
            6: step(8, 0, 0);
            default: ;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: decode sweep while held in reset.
        repeat (2) @(posedge clk);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {cs_n, ras_n, cas_n, we_n} = 4'(p);
            #1;
            chk("R1 decode", int'(cmd_code), (p >= 8) ? 0 : 8 - (p % 8));
        end

        // R10: reset state.
        do_reset();
        #1;
        chk("R10 bank0 idle", bs(0), 0);
        chk("R10 bank1 idle", bs(1), 0);
        chk("R10 flag clear", int'(err_flag), 0);

        // Full state x command sweep on bank 0.
        for (int s = 0; s < 7; s++) begin
            for (int c = 0; c < 9; c++) begin
                do_reset();
                setup(s);
                chk({tag(s), " setup state"}, bs(0), s);
                step(c, 0, 0);
                chk({tag(s), " flag"}, int'(err_flag), legal_exp(s, c) ? 0 : 1);
                if (!legal_exp(s, c)) begin
                    chk({tag(s), " err_cmd"}, int'(err_cmd), c);
                    chk({tag(s), " err_bank"}, int'(err_bank), 0);
                    chk({tag(s), " err_state"}, int'(err_state), s);
                    chk("R9 refused bank unchanged", bs(0), s);
                end
            end
        end

        // R3: return to row active after T_DPL.
        do_reset();
        step(5, 0, 0); step(4, 0, 0);
        for (int k = 1; k <= T_DPL; k++) begin
            step(1, 0, 0);
            chk("R3 recovery window", bs(0), (k < T_DPL) ? 2 : 1);
        end
        // R3: rewrite restarts, read leaves at once.
        step(4, 0, 0); step(4, 0, 0); step(1, 0, 0);
        chk("R3 rewrite restarts", bs(0), 2);
        step(3, 0, 0);
        chk("R3 read ends recovery", bs(0), 1);
        chk("R3 no flag", int'(err_flag), 0);

        // R5: auto-precharge recovery then precharge then idle.
        do_reset();
        step(5, 0, 0); step(4, 0, 1);
        for (int k = 1; k <= T_DPL + T_RP; k++) begin
            step(1, 0, 0);
            chk("R5 window", bs(0), (k < T_DPL) ? 3 : (k < T_DPL + T_RP) ? 4 : 0);
        end
        do_reset();
        step(5, 0, 0); step(4, 0, 1); step(5, 1, 0);
        chk("R5 other bank activate flag", int'(err_flag), 0);
        chk("R5 other bank active", bs(1), 1);

        // R6: refresh both banks, idle after T_RC.
        do_reset();
        step(7, 0, 0);
        for (int k = 1; k <= T_RC; k++) begin
            step(1, 0, 0);
            chk("R6 bank0", bs(0), (k < T_RC) ? 5 : 0);
            chk("R6 bank1", bs(1), (k < T_RC) ? 5 : 0);
        end

        // R7: command two clocks after mode set is judged as idle.
        do_reset();
        step(8, 0, 0); step(1, 0, 0); step(5, 0, 0);
        chk("R7 activate after window", int'(err_flag), 0);
        chk("R7 bank active", bs(0), 1);

        // R2: precharge all versus single bank.
        do_reset();
        step(5, 0, 0); step(5, 1, 0); step(6, 0, 0);
        chk("R2 single precharge b0", bs(0), 4);
        chk("R2 single precharge b1", bs(1), 1);
        do_reset();
        step(5, 0, 0); step(5, 1, 0); step(6, 0, 1);
        chk("R2 precharge all b0", bs(0), 4);
        chk("R2 precharge all b1", bs(1), 4);
        do_reset();
        step(5, 0, 0); step(5, 1, 0); step(4, 1, 0); step(6, 0, 1);
        chk("R2 all-bank vs recovery flag", int'(err_flag), 1);
        chk("R9 lowest offender bank", int'(err_bank), 1);
        chk("R4 recorded state", int'(err_state), 2);

        // R8: clock-enable gating.
        do_reset();
        step(5, 0, 0);
        cke = 1'b0;
        step(5, 0, 0);
        chk("R8 cke low not flagged", int'(err_flag), 0);
        chk("R8 cke low no change", bs(0), 1);
        cke = 1'b1;
        step(5, 0, 0);
        chk("R8 cke rising cycle not flagged", int'(err_flag), 0);
        step(5, 0, 0);
        chk("R8 cke steady flagged", int'(err_flag), 1);
        chk("R9 err_cmd", int'(err_cmd), 5);
        chk("R9 err_state", int'(err_state), 1);

        // R9: first record kept, clear, clear with offence.
        step(3, 1, 0);
        chk("R9 still flagged", int'(err_flag), 1);
        chk("R9 first record kept", int'(err_cmd), 5);
        step(1, 0, 0); step(1, 0, 0);
        chk("R9 sticky", int'(err_flag), 1);
        err_clr = 1'b1;
        step(1, 0, 0);
        chk("R9 cleared", int'(err_flag), 0);
        step(3, 1, 0);
        err_clr = 1'b0;
        chk("R9 clear with offence flag", int'(err_flag), 1);
        chk("R9 new record cmd", int'(err_cmd), 3);
        chk("R9 new record bank", int'(err_bank), 1);
        chk("R9 new record state", int'(err_state), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule